// File: doc/BRIEF.md
# Quarter-Wave Table Sine/Cosine Oscillator

The block is a numerically controlled tone source. A wide phase register advances by a programmable step on every cycle where the sample enable is high, so the tone frequency is the enable rate times the step divided by 2^32. A programmable phase offset is added to the running phase, and the eight most significant bits of that sum select one point of a 256-point cycle.

The cycle is rebuilt from a table that holds only the first quarter of a sine wave, 64 magnitudes. The two upper index bits fold the table address and set the sign. The cosine uses the same table with the index advanced by a quarter cycle. Each output can be a two's-complement sample for signal processing downstream, or an offset-binary code that drives a 10-bit DAC directly.

Top module: `dds_quarter_osc`

## Requirements
- R1: While rst_ni is low, sin_o and cos_o read 0 and the phase register is cleared. With offset 0 the first sample shown after reset (second enable) is sine 0 and cosine 511, which is signed full scale.
- R2: Every enable adds step_i to the 32-bit phase, modulo 2^32. After the k-th enable following reset (k >= 2) the outputs show the wave at index P[31:24], where P = (k-2)*step_i + offset_i modulo 2^32. The fractional low bits carry into the index, so the frequency is f_en*step/2^32.
- R3: Table entry a (0..63) holds round(256*sin(a*90/64 degrees)) as an unsigned 8.8 value in the range 0..256. Entry 21 is 0x007E.
- R4: Index bits [7:6] form quadrant q and bits [5:0] form address a. When q is 1 or 3 the table is read at 63-a. When q is 2 or 3 the magnitude is negated.
- R5: The cosine output is the same wave evaluated at index (i+64) mod 256, where i is the sine index.
- R6: With fmt_i=0 each output is a 10-bit two's-complement value of +/-2*magnitude. Results are clamped to 511 and -512.
- R7: With fmt_i=1 each output is the R6 value plus 512, an unsigned code from 0 to 1023.
- R8: On cycles where sample_en_i is low, sin_o, cos_o and the phase register do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample-rate enable |
| step_i | input | 32 | Phase increment per enable |
| offset_i | input | 32 | Phase offset added before indexing |
| fmt_i | input | 1 | 0 = two's complement, 1 = offset binary |
| sin_o | output | 10 | Sine sample |
| cos_o | output | 10 | Cosine sample |

## Verification
A step of exactly one index per enable walks all 256 indices in both output formats. This separates table contents, the address mirror, the sign flip, the quarter-cycle cosine shift and the positive clamp at index 64. A step with nonzero low bits, together with an odd offset, shows whether the fraction carries into the index and whether the offset is applied. Idle gaps between enables show whether anything moves without an enable. A step that counts downward through the halfway offset exercises wraparound in the offset-binary mapping.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real PI = 3.14159265358979323846;

  // magnitude of quarter-wave entry a, scaled by 2^frac_w, rounded to nearest
  function automatic int quarter_mag(int a, int addr_w, int frac_w);
    real ang;
    ang = (real'(a) * PI) / (2.0 * real'(1 << addr_w));
    return $rtoi($floor(real'(1 << frac_w) * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] step_i,
  input  logic [PHASE_W-1:0] offset_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] phase_sum;
  logic [IDX_W-1:0]   idx_q;

  assign phase_sum = acc_q + offset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_q + step_i;
      idx_q <= phase_sum[PHASE_W-1 -: IDX_W];
    end
  end

  assign idx_o = idx_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q) && $stable(idx_q)); // R8
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int ADDR_W = 6,
  parameter int FRAC_W = 8,
  localparam int ENTRIES = 1 << ADDR_W,
  localparam int MAG_W   = FRAC_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MAG_W-1:0]  mag_o
);
  logic [MAG_W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int ENT = dds_pkg::quarter_mag(i, ADDR_W, FRAC_W);
    assign tbl[i] = MAG_W'(ENT);
  end

  assign mag_o = tbl[addr_i];
endmodule

// File: rtl/dds_fold.sv
module dds_fold #(
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 8,
  localparam int ADDR_W = IDX_W - 2,
  localparam int MAG_W  = FRAC_W + 1
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             neg_o
);
  logic [ADDR_W-1:0] raw_addr;
  logic [ADDR_W-1:0] tbl_addr;

  assign raw_addr = idx_i[ADDR_W-1:0];
  // odd quadrants run the table backwards: ~a == (2^ADDR_W - 1) - a
  assign tbl_addr = idx_i[ADDR_W] ? ~raw_addr : raw_addr;
  assign neg_o    = idx_i[IDX_W-1];

  dds_quarter_rom #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_rom (
    .addr_i(tbl_addr),
    .mag_o (mag_o)
  );
endmodule

// File: rtl/dds_fmt.sv
module dds_fmt #(
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 10,
  localparam int MAG_W = FRAC_W + 1,
  localparam int SH    = OUT_W - 1 - FRAC_W,
  localparam int WW    = OUT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fmt_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             neg_i,
  output logic [OUT_W-1:0] out_o
);
  localparam logic signed [WW-1:0] MAXV = WW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [WW-1:0] MINV = -WW'(1 << (OUT_W - 1));

  logic signed [WW-1:0] scaled;
  logic signed [WW-1:0] signed_v;
  logic signed [WW-1:0] clamped;
  logic [OUT_W-1:0]     coded;
  logic [OUT_W-1:0]     out_q;

  assign scaled   = $signed({{(WW-MAG_W){1'b0}}, mag_i}) <<< SH;
  assign signed_v = neg_i ? -scaled : scaled;

  always_comb begin
    if (signed_v > MAXV)      clamped = MAXV;
    else if (signed_v < MINV) clamped = MINV;
    else                      clamped = signed_v;
  end

  // offset binary = two's complement with the sign bit inverted
  assign coded = fmt_i ? {~clamped[OUT_W-1], clamped[OUT_W-2:0]} : clamped[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_q <= '0;
    else if (en_i) out_q <= coded;
  end

  assign out_o = out_q;

  AST_POS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !fmt_i && !neg_i |=> !out_q[OUT_W-1]); // R6
  AST_NEG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && fmt_i && neg_i && (mag_i != '0) |=> !out_q[OUT_W-1]); // R7
endmodule

// File: rtl/dds_quarter_osc.sv
module dds_quarter_osc #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int OUT_W   = 10,
  localparam int MAG_W  = FRAC_W + 1,
  localparam int NCH    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_en_i,
  input  logic [PHASE_W-1:0] step_i,
  input  logic [PHASE_W-1:0] offset_i,
  input  logic               fmt_i,
  output logic [OUT_W-1:0]   sin_o,
  output logic [OUT_W-1:0]   cos_o
);
  logic [IDX_W-1:0]            idx_q;
  logic [NCH-1:0][OUT_W-1:0]   ch_out;

  dds_phase_acc #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sample_en_i),
    .step_i  (step_i),
    .offset_i(offset_i),
    .idx_o   (idx_q)
  );

  // channel 0 = sine, channel 1 = cosine (index advanced a quarter cycle)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [IDX_W-1:0] QOFS = IDX_W'(ch) << (IDX_W - 2);
    logic [IDX_W-1:0] ch_idx;
    logic [MAG_W-1:0] mag;
    logic             neg;

    assign ch_idx = idx_q + QOFS;

    dds_fold #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_fold (
      .idx_i(ch_idx),
      .mag_o(mag),
      .neg_o(neg)
    );

    dds_fmt #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_fmt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (sample_en_i),
      .fmt_i (fmt_i),
      .mag_i (mag),
      .neg_i (neg),
      .out_o (ch_out[ch])
    );

    AST_MAG_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mag <= MAG_W'(1 << FRAC_W)); // R3
  end

  assign sin_o = ch_out[0];
  assign cos_o = ch_out[1];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(sin_o) && $stable(cos_o)); // R8
endmodule

// File: tb/dds_quarter_osc_bench.sv
module dds_quarter_osc_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_en_i = 1'b0;
  logic [31:0] step_i = '0;
  logic [31:0] offset_i = '0;
  logic        fmt_i = 1'b0;
  logic [9:0]  sin_o, cos_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dds_quarter_osc u_dds_quarter_osc (
    .clk_i(clk), .rst_ni(rst_ni), .sample_en_i(sample_en_i),
    .step_i(step_i), .offset_i(offset_i), .fmt_i(fmt_i),
    .sin_o(sin_o), .cos_o(cos_o)
  );

  function automatic int mag_of(int a);
    return $rtoi($floor(256.0 * $sin(real'(a) * 3.14159265358979323846 / 128.0) + 0.5));
  endfunction

  function automatic int wave(int idx, bit f);
    int q, a, v;
    q = (idx >> 6) & 3;
    a = idx & 63;
    if (q[0]) a = 63 - a;
    v = 2 * mag_of(a);
    if (q[1]) v = -v;
    if (v > 511) v = 511;
    if (v < -512) v = -512;
    if (f) v = v + 512;
    return v;
  endfunction

  function automatic int as_int(logic [9:0] x, bit f);
    return f ? int'(x) : int'($signed(x));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    sample_en_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 sin reset", int'(sin_o), 0);
    chk("R1 cos reset", int'(cos_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic run(logic [31:0] st, logic [31:0] off, bit f, int n, bit gaps);
    logic [31:0] ph;
    int ix;
    logic [9:0] hs, hc;
    do_reset();
    step_i = st; offset_i = off; fmt_i = f;
    for (int k = 1; k <= n; k++) begin
      sample_en_i = 1'b1;
      @(posedge clk); #1;
      sample_en_i = 1'b0;
      if (k >= 2) begin
        ph = st * 32'(k - 2) + off;
        ix = int'(ph[31:24]);
        chk("R2/R4/R6/R7 sin", as_int(sin_o, f), wave(ix, f));
        chk("R5 cos", as_int(cos_o, f), wave((ix + 64) & 255, f));
        if (k == 2 && off == 0 && !f) begin
          chk("R1 first sin", as_int(sin_o, f), 0);
          chk("R1 first cos", as_int(cos_o, f), 511);
        end
        if (ix == 21 && !f) chk("R3 entry21", as_int(sin_o, f), 2 * 'h7E);
        if (ix == 64 && !f) chk("R6 clamp", as_int(sin_o, f), 511);
        if (ix == 192 && !f) chk("R6 neg full", as_int(sin_o, f), -512);
        if (ix == 0 && f) chk("R7 midcode", as_int(sin_o, f), 512);
      end
      if (gaps && (k % 3 == 0)) begin
        hs = sin_o; hc = cos_o;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 sin hold", int'(sin_o), int'(hs));
        chk("R8 cos hold", int'(cos_o), int'(hc));
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    run(32'h0100_0000, 32'h0000_0000, 1'b0, 258, 1'b0);
    run(32'h0100_0000, 32'h0000_0000, 1'b1, 258, 1'b0);
    run(32'h0270_1234, 32'h3FF0_0000, 1'b0, 300, 1'b1);
    run(32'hFF00_0000, 32'h8000_0000, 1'b1, 120, 1'b1);
    run(32'h0080_0001, 32'h0000_0000, 1'b0, 200, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule